// File: doc/BRIEF.md
# Split-Read 40-bit Time Base

This block keeps a 40-bit up-counter that advances once for every pulse on a tick-enable input (nominally 983.04 kHz, produced outside the block). Software on a 32-bit register bus sees it through two read ports. The low-word port returns counter bits 31:0. In the same clock edge, the block copies bits 39:32 into a holding byte. The high-word port returns that held byte next to the run-enable flag, so a low-then-high read pair always yields a 40-bit value taken at one instant, even when a carry crosses into the upper byte between the two bus accesses.

Setting the enable flag, bit 8 of the high-word register, starts the count. Clearing it stops the count and keeps the value. The block has no interrupt. Read data is registered: it appears on the cycle after the read strobe. On every cycle without a read strobe the read data is zero.

Top module: `tsc_timebase`

## Requirements
- R1: After synchronous reset the counter, the held byte and the enable flag are all zero, so both registers read back zero.
- R2: A read strobe at offset 0x60 returns counter bits 31:0 on bus_rdata in the following cycle. The value returned is the count held just before that clock edge.
- R3: A read at 0x60 copies counter bits 39:32 into the held byte at the same edge. A later read at 0x64 returns that byte even if the counter has since carried into its upper byte.
- R4: A read at 0x64 returns the held byte in bits 7:0 and the enable flag in bit 8, with all other bits zero. A read at 0x64 does not change the held byte.
- R5: While enabled, the counter increases by exactly one at each clock edge where tick is high. Ticks that arrive while the block is disabled are ignored.
- R6: Clearing the enable flag freezes the count at its current value. Setting the flag again resumes counting from that value.
- R7: The counter wraps from all ones to zero.
- R8: A write at 0x64 sets the enable flag from bus_wdata bit 8 and ignores every other data bit. Writes to any other offset, including 0x60, have no effect.
- R9: bus_rdata is zero in every cycle that does not follow a read strobe. A read of an unmapped offset returns zero.
- R10: A read at 0x60 and a tick at the same edge give the pre-tick value. Reads at two adjacent edges under a continuous tick differ by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle count-enable pulse |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |

## Verification
The case that is hardest to reach is a carry out of bit 31 that lands between the low read and the high read. Reaching it through the ports would take four billion ticks. The bench therefore also runs a second copy of the block with a 14-bit counter and a 10-bit word. Its upper field carries every 1024 ticks and the whole counter wraps after 16384 ticks. The bench uses its own reference count to start a low read exactly when the low field is all ones, and again when the whole counter is all ones, then checks the following high read and low read against the snapshot.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int ADDR_W   = 8;
    localparam logic [ADDR_W-1:0] OFF_LOW  = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_HIGH = 8'h64;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_LOW   = 2'd1,
        SEL_HIGH  = 2'd2,
        SEL_OTHER = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } bus_op_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        if (a == OFF_LOW)       return SEL_LOW;
        else if (a == OFF_HIGH) return SEL_HIGH;
        else                    return SEL_OTHER;
    endfunction

endpackage

// File: rtl/tsc_counter.sv
module tsc_counter #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (run && tick) cnt <= cnt + STEP;
    end

    // R5: one step per enabled tick, wrapping at the top (R7)
    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (run && tick) |=> (cnt == $past(cnt) + STEP));

    // R6: no enabled tick, no change
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(run && tick) |=> $stable(cnt));

endmodule

// File: rtl/tsc_latch.sv
module tsc_latch #(
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap,
    input  logic [HI_W-1:0] hi_in,
    output logic [HI_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst)      held <= '0;
        else if (cap) held <= hi_in;
    end

    // R3: the snapshot takes the upper field seen at the capturing edge
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        cap |=> (held == $past(hi_in)));

    // R4: nothing but a low read moves the held byte
    p_keep_r4: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(held));

endmodule

// File: rtl/tsc_regif.sv
module tsc_regif
    import tsc_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int HI_W   = 8,
    parameter int EN_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en_bit,
    input  logic [BUS_W-1:0]  cnt_low,
    input  logic [HI_W-1:0]   held,
    output logic [BUS_W-1:0]  rdata,
    output logic              run,
    output logic              cap
);
    bus_op_t          op;
    logic [BUS_W-1:0] hi_word;
    logic [BUS_W-1:0] rd_next;

    always_comb begin
        op.rd  = bus_rd;
        op.wr  = bus_wr;
        op.sel = decode_sel(bus_addr);
    end

    assign cap = op.rd && (op.sel == SEL_LOW);

    always_comb begin
        hi_word                = '0;
        hi_word[HI_W-1:0]      = held;
        hi_word[EN_BIT]        = run;
    end

    always_comb begin
        rd_next = '0;
        if (op.rd) begin
            unique case (op.sel)
                SEL_LOW:  rd_next = cnt_low;
                SEL_HIGH: rd_next = hi_word;
                default:  rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            run   <= 1'b0;
        end else begin
            rdata <= rd_next;
            if (op.wr && op.sel == SEL_HIGH) run <= wr_en_bit;
        end
    end

    // R9: no strobe, zero data next cycle
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (rdata == '0));

    // R8: enable follows the written bit
    p_en_write_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && op.sel == SEL_HIGH) |=> (run == $past(wr_en_bit)));

    // R8: other writes leave the enable alone
    p_en_other_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && op.sel == SEL_HIGH) |=> $stable(run));

    // R4: high read carries the enable state of the read edge
    p_hi_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && op.sel == SEL_HIGH) |=> (rdata[EN_BIT] == $past(run)));

endmodule

// File: rtl/tsc_timebase.sv
module tsc_timebase
    import tsc_pkg::*;
#(
    parameter int CNT_W  = 40,
    parameter int BUS_W  = 32,
    parameter int EN_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);
    localparam int HI_W = CNT_W - BUS_W;

    logic [CNT_W-1:0] cnt;
    logic [HI_W-1:0]  held;
    logic             run;
    logic             cap;

    tsc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick),
        .cnt  (cnt)
    );

    tsc_latch #(.HI_W(HI_W)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .cap   (cap),
        .hi_in (cnt[CNT_W-1:BUS_W]),
        .held  (held)
    );

    tsc_regif #(.BUS_W(BUS_W), .HI_W(HI_W), .EN_BIT(EN_BIT)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .wr_en_bit (bus_wdata[EN_BIT]),
        .cnt_low   (cnt[BUS_W-1:0]),
        .held      (held),
        .rdata     (bus_rdata),
        .run       (run),
        .cap       (cap)
    );

    // R2: a low read returns the pre-edge low word
    p_low_read_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_LOW) |=> (bus_rdata == $past(cnt[BUS_W-1:0])));

endmodule

// File: tb/tb_tsc_timebase.sv
module tb_tsc_timebase;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_m;
    logic [9:0]  rdata_s;

    int n_chk = 0;
    int n_bad = 0;
    int tick_mode = 0;
    int tick_ph = 0;
    bit done = 0;

    longint m_cnt [2] = '{0, 0};
    longint m_lat [2] = '{0, 0};
    longint m_exp [2] = '{0, 0};
    longint m_mask[2] = '{64'hFF_FFFF_FFFF, 64'h3FFF};
    int     m_bw  [2] = '{32, 10};
    bit     m_en = 0;
    string  m_tag = "R1";

    always #2 clk = ~clk;

    tsc_timebase dut (
        .clk(clk), .rst(rst), .tick(tick), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_m));

    tsc_timebase #(.CNT_W(14), .BUS_W(10), .EN_BIT(8)) dut_small (
        .clk(clk), .rst(rst), .tick(tick), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata[9:0]), .bus_rdata(rdata_s));

    task automatic chk(input longint act, input longint exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced at every edge
    always @(posedge clk) begin
        bit old_en;
        old_en = m_en;
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_lat[i] = 0; m_exp[i] = 0;
            end
            m_en = 0; m_tag = "R1";
        end else begin
            m_tag = "R9";
            for (int i = 0; i < 2; i++) begin
                m_exp[i] = 0;
                if (bus_rd && bus_addr == 8'h60) begin
                    m_exp[i] = m_cnt[i] & ((64'd1 << m_bw[i]) - 1);
                    m_lat[i] = m_cnt[i] >> m_bw[i];
                    m_tag = "R2";
                end else if (bus_rd && bus_addr == 8'h64) begin
                    m_exp[i] = m_lat[i] | (longint'(old_en) << 8);
                    m_tag = "R4";
                end
                if (tick && old_en) m_cnt[i] = (m_cnt[i] + 1) & m_mask[i];
            end
            if (bus_wr && bus_addr == 8'h64) m_en = bus_wdata[8];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(rdata_m, m_exp[0], m_tag);
            chk(rdata_s, m_exp[1], m_tag);
        end
        tick_ph++;
        case (tick_mode)
            1: tick <= 1'b1;
            2: tick <= (tick_ph % 3 == 0);
            default: tick <= 1'b0;
        endcase
    end

    task automatic rd(input logic [7:0] a);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    endtask

    initial begin
        longint v1;
        longint v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rdata_m, 0, "R1");
        rd(8'h60); chk(rdata_m, 0, "R1");
        rd(8'h64); chk(rdata_m, 0, "R1");

        // R8: other bits and the low offset cannot enable; R5 ticks ignored
        tick_mode = 1;
        wr(8'h64, 32'hFFFF_FEFF);
        wr(8'h60, 32'h0000_0100);
        repeat (10) @(negedge clk);
        rd(8'h64); chk(rdata_m, 0, "R8");
        rd(8'h60); chk(rdata_m, 0, "R5");

        wr(8'h64, 32'h0000_0100);
        repeat (20) @(negedge clk);
        rd(8'h64); chk(rdata_m, 32'h100, "R4");
        rd(8'h68); chk(rdata_m, 0, "R9");

        // R10: adjacent low reads under continuous ticking
        rd(8'h60); v1 = rdata_m;
        rd(8'h60); v2 = rdata_m;
        chk(v2, v1 + 1, "R10");

        tick_mode = 2;
        repeat (40) begin
            rd(8'h60);
            @(negedge clk);
            rd(8'h64);
        end

        // R6: freeze and resume
        wr(8'h64, 32'h0);
        rd(8'h60); v1 = rdata_m;
        tick_mode = 1;
        repeat (15) @(negedge clk);
        rd(8'h60); chk(rdata_m, v1, "R6");
        wr(8'h64, 32'h100);
        repeat (5) @(negedge clk);
        rd(8'h60); chk(rdata_m > v1 ? 1 : 0, 1, "R6");

        // R3: snapshot taken when the small low field is all ones
        for (int k = 0; k < 3; k++) begin
            while ((m_cnt[1] & 10'h3FF) != 10'h3FF) @(negedge clk);
            v1 = m_cnt[1] >> 10;
            rd(8'h60); chk(rdata_s, 10'h3FF, "R3");
            repeat (3) @(negedge clk);
            rd(8'h64); chk(rdata_s, v1 | 10'h100, "R3");
        end

        // R7: whole small counter at all ones, then zero
        while (m_cnt[1] != 14'h3FFF) @(negedge clk);
        rd(8'h60); chk(rdata_s, 10'h3FF, "R7");
        rd(8'h64); chk(rdata_s, 10'h10F, "R7");
        rd(8'h60); chk(rdata_s, 1, "R7");

        tick_mode = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule